// File: doc/BRIEF.md
# Vector Float/Integer Lane Converter

This unit converts every lane of a vector word between IEEE floating point and two's-complement integers. A 2-bit operation code picks one of four directions. Two of them turn floats into integers: single precision to 32-bit integer, and half precision to 16-bit integer. The other two turn integers into floats: 32-bit integer to single precision, and 16-bit integer to half precision. The lane width follows the operation. Lane i of the source becomes lane i of the result, so the vector's lane count is unchanged.

Float-to-integer conversion always truncates toward zero. It saturates values that fall outside the integer range. A NaN saturates according to its sign bit, rather than always to the positive maximum. Integer-to-float conversion is exact when the value fits in the significand, and otherwise rounds to nearest with ties to even.

The unit has one register stage. A word presented with valid_i set appears on vec_o together with valid_o on the next clock edge. vec_o holds its value while valid_i is low.

Top module: `vconv_unit`

## Requirements
- R1: The op_i encoding is 0 for single to int32, 1 for half to int16, 2 for int32 to single and 3 for int16 to half. Lane i occupies bits [32*i +: 32] for ops 0 and 2 and bits [16*i +: 16] for ops 1 and 3, and each lane is converted independently of the others.
- R2: Float-to-integer results truncate toward zero: 2.75 gives 2 and -2.75 gives -2.
- R3: A float whose magnitude is below 1 gives 0. This covers both signed zeros and all subnormals.
- R4: A NaN with the sign bit clear gives the positive maximum of the lane width (0x7FFFFFFF or 0x7FFF). A NaN with the sign bit set gives the negative minimum (0x80000000 or 0x8000).
- R5: Infinities, and finite floats whose truncated value lies outside the integer range, saturate by sign to the maximum or the minimum.
- R6: Integer-to-float conversion is exact when the magnitude fits in the significand. Otherwise it rounds to nearest with ties to even: 16777217 gives 0x4B800000, 16777219 gives 0x4B800002, and 0x7FFFFFFF gives 0x4F000000.
- R7: int16 to half rounds to nearest-even above 2048: 2049 gives 0x6800, 2051 gives 0x6802, 32767 gives 0x7800, and -32768 gives 0xF800.
- R8: valid_o is valid_i delayed by one cycle, and vec_o then carries the conversion of the vec_i and op_i of that cycle. vec_o holds its value while valid_i is low.
- R9: While rst_ni is low, valid_o and vec_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid |
| op_i | input | 2 | Conversion selector |
| vec_i | input | VEC_W | Source vector |
| valid_o | output | 1 | Result is valid |
| vec_o | output | VEC_W | Converted vector |

## Verification
The bench targets the boundary of the integer range and the NaN cases. A converter that saturated every NaN to the positive maximum would return 0x7FFFFFFF for a negative NaN. A converter with an off-by-one range test would wrap 2^31 or 2^15 instead of clamping. Values just below one and subnormal inputs catch rounding to nearest in place of truncation, which would give 1 where 0 is required. Integer inputs one and three units past the significand's reach catch rounding that is not ties-to-even, or that loses the carry into the exponent, such as 32767 failing to become 32768.

// File: rtl/vconv_pkg.sv
package vconv_pkg;
  typedef enum logic [1:0] {
    OP_F32_TO_I32 = 2'd0,
    OP_F16_TO_I16 = 2'd1,
    OP_I32_TO_F32 = 2'd2,
    OP_I16_TO_F16 = 2'd3
  } conv_op_e;

  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int HP_EXP_W = 5;
  localparam int HP_MAN_W = 10;
  localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
  localparam int HP_W     = 1 + HP_EXP_W + HP_MAN_W;
endpackage

// File: rtl/vconv_f2i_lane.sv
// Float to same-width signed integer, truncating, saturating by sign.
module vconv_f2i_lane #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] fp_i,
  output logic [W-1:0] int_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic [W-1:0]     sig;
  logic [W-1:0]     mag;
  logic [W-1:0]     sat;
  int               ue;

  always_comb begin
    sgn   = fp_i[W-1];
    ex    = fp_i[W-2 -: EXP_W];
    man   = fp_i[MAN_W-1:0];
    ue    = int'({1'b0, ex}) - BIAS;
    sig   = '0;
    sig[MAN_W:0] = {1'b1, man};
    sat   = sgn ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    mag   = '0;
    int_o = '0;
    if (ex == '1) begin
      int_o = sat;                       // NaN and infinity by sign
    end else if (ue < 0) begin
      int_o = '0;                        // |x| < 1, zero, subnormal
    end else if (ue >= W - 1) begin
      int_o = sat;
    end else begin
      if (ue >= MAN_W) mag = sig << (ue - MAN_W);
      else             mag = sig >> (MAN_W - ue);
      int_o = sgn ? (~mag + 1'b1) : mag;
    end
  end
endmodule

// File: rtl/vconv_i2f_lane.sv
// Signed integer to same-width float, round to nearest even.
module vconv_i2f_lane #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int PW   = $clog2(W)
) (
  input  logic [W-1:0] int_i,
  output logic [W-1:0] fp_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic               sgn;
  logic [W-1:0]       mag;
  logic [W-1:0]       norm;
  logic [PW-1:0]      lead;
  logic [EXP_W-1:0]   ex;
  logic [MAN_W-1:0]   man;
  logic               grd;
  logic               stk;
  logic [W-2:0]       body;

  always_comb begin
    sgn  = int_i[W-1];
    mag  = sgn ? (~int_i + 1'b1) : int_i;
    lead = '0;
    for (int b = 0; b < W; b++) begin
      if (mag[b]) lead = PW'(b);
    end
    norm = mag << (PW'(W - 1) - lead);
    man  = norm[W-2 -: MAN_W];
    grd  = norm[W-2-MAN_W];
    stk  = |norm[W-3-MAN_W:0];
    ex   = EXP_W'(lead) + EXP_W'(BIAS);
    body = {ex, man};
    // carry out of mantissa bumps exponent
    if (grd && (stk || man[0])) body = body + 1'b1;
    fp_o = (mag == '0) ? '0 : {sgn, body};
  end
endmodule

// File: rtl/vconv_unit.sv
module vconv_unit
  import vconv_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int N_SP = VEC_W / SP_W;
  localparam int N_HP = VEC_W / HP_W;

  logic [VEC_W-1:0] f2i_sp, i2f_sp, f2i_hp, i2f_hp;
  logic [VEC_W-1:0] res_d;

  for (genvar g = 0; g < N_SP; g++) begin : g_sp
    vconv_f2i_lane #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_f2i (
      .fp_i (vec_i[g*SP_W +: SP_W]),
      .int_o(f2i_sp[g*SP_W +: SP_W])
    );
    vconv_i2f_lane #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_i2f (
      .int_i(vec_i[g*SP_W +: SP_W]),
      .fp_o (i2f_sp[g*SP_W +: SP_W])
    );
  end

  for (genvar g = 0; g < N_HP; g++) begin : g_hp
    vconv_f2i_lane #(.EXP_W(HP_EXP_W), .MAN_W(HP_MAN_W)) u_f2i (
      .fp_i (vec_i[g*HP_W +: HP_W]),
      .int_o(f2i_hp[g*HP_W +: HP_W])
    );
    vconv_i2f_lane #(.EXP_W(HP_EXP_W), .MAN_W(HP_MAN_W)) u_i2f (
      .int_i(vec_i[g*HP_W +: HP_W]),
      .fp_o (i2f_hp[g*HP_W +: HP_W])
    );
  end

  always_comb begin
    unique case (conv_op_e'(op_i))
      OP_F32_TO_I32: res_d = f2i_sp;
      OP_F16_TO_I16: res_d = f2i_hp;
      OP_I32_TO_F32: res_d = i2f_sp;
      OP_I16_TO_F16: res_d = i2f_hp;
      default:       res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) vec_o <= res_d;
    end
  end
endmodule

// File: rtl/vconv_unit_chk.sv
module vconv_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       op_i,
  input logic [VEC_W-1:0] vec_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] vec_o
);
  p_valid_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(vec_o));
  p_neg_nan_sp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && vec_i[31] && vec_i[30:23] == 8'hFF && vec_i[22:0] != '0)
    |=> vec_o[31:0] == 32'h8000_0000);
  p_pos_nan_sp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && !vec_i[31] && vec_i[30:23] == 8'hFF && vec_i[22:0] != '0)
    |=> vec_o[31:0] == 32'h7FFF_FFFF);
  p_neg_nan_hp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1 && vec_i[15] && vec_i[14:10] == 5'h1F && vec_i[9:0] != '0)
    |=> vec_o[15:0] == 16'h8000);
  p_below_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0 && vec_i[30:23] < 8'd127) |=> vec_o[31:0] == '0);
  p_int_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2 && vec_i[31:0] == '0) |=> vec_o[31:0] == '0);
  p_reset_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && vec_o == '0));
endmodule

bind vconv_unit vconv_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .vec_i  (vec_i),
  .valid_o(valid_o),
  .vec_o  (vec_o)
);

// File: tb/vconv_unit_tb.sv
module vconv_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W      = 128;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic [1:0]       op_i = '0;
  logic [VEC_W-1:0] vec_i = '0;
  logic             valid_o;
  logic [VEC_W-1:0] vec_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [VEC_W-1:0] exp_q[$];
  string            req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vconv_unit #(.VEC_W(VEC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .vec_i(vec_i), .valid_o(valid_o), .vec_o(vec_o)
  );

  function automatic logic [VEC_W-1:0] p32(input logic [31:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  function automatic logic [VEC_W-1:0] p16(input logic [15:0] a, b, c, d, e, f, g, h);
    return {h, g, f, e, d, c, b, a};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [VEC_W-1:0] vin,
                      input logic [VEC_W-1:0] vexp, input string req);
    @(negedge clk);
    valid_i = 1'b1;
    op_i    = op;
    vec_i   = vin;
    exp_q.push_back(vexp);
    req_q.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected valid_o", vec_o, '0);
      end else begin
        logic [VEC_W-1:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(vec_o === e, r, vec_o, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid_o === 1'b0 && vec_o === '0, "R9 reset state", vec_o, '0);
    rst_n = 1'b1;

    // R1 R2 R3: truncation, below one, subnormal
    send(2'd0, p32(32'h4030_0000, 32'hC030_0000, 32'h3F7F_FFFF, 32'h0000_0001),
               p32(32'd2, 32'hFFFF_FFFE, 32'd0, 32'd0), "R1 R2 R3 f32->i32");
    // R4 NaN by sign
    send(2'd0, p32(32'h7FC0_0000, 32'hFFC0_0000, 32'h7F80_0001, 32'hFF80_0001),
               p32(32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000), "R4 f32 NaN");
    // R5 infinities and range edge
    send(2'd0, p32(32'h7F80_0000, 32'hFF80_0000, 32'h4F00_0000, 32'hCF00_0000),
               p32(32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000), "R5 f32 saturate");
    send(2'd0, p32(32'h4EFF_FFFF, 32'h8000_0000, 32'h3F80_0000, 32'hC300_0000),
               p32(32'h7FFF_FF80, 32'd0, 32'd1, 32'hFFFF_FF80), "R1 R2 R3 f32 in-range edge");
    // half precision
    send(2'd1, p16(16'h4180, 16'hC180, 16'h3BFF, 16'h0001, 16'h7E00, 16'hFE00, 16'h7C00, 16'hFC00),
               p16(16'h0002, 16'hFFFE, 16'h0000, 16'h0000, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000),
               "R1 R2 R3 R4 R5 f16->i16");
    send(2'd1, p16(16'h7800, 16'hF800, 16'h77FF, 16'h7BFF, 16'hFBFF, 16'h3C00, 16'h8000, 16'hD640),
               p16(16'h7FFF, 16'h8000, 16'h7FF0, 16'h7FFF, 16'h8000, 16'h0001, 16'h0000, 16'hFF9C),
               "R5 R2 f16 range");
    // int32 -> single
    send(2'd2, p32(32'd0, 32'd1, 32'hFFFF_FFFF, 32'h8000_0000),
               p32(32'd0, 32'h3F80_0000, 32'hBF80_0000, 32'hCF00_0000), "R1 R6 i32->f32 exact");
    send(2'd2, p32(32'h0100_0001, 32'h0100_0003, 32'h7FFF_FFFF, 32'd100),
               p32(32'h4B80_0000, 32'h4B80_0002, 32'h4F00_0000, 32'h42C8_0000), "R6 i32->f32 rounding");
    // int16 -> half
    send(2'd3, p16(16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h0801, 16'h0803, 16'h7FFF, 16'h07FF),
               p16(16'h0000, 16'h3C00, 16'hBC00, 16'hF800, 16'h6800, 16'h6802, 16'h7800, 16'h67FF),
               "R1 R7 i16->f16");
    send(2'd3, p16(16'd100, 16'hFF9C, 16'h0802, 16'hF7FF, 16'd0, 16'd0, 16'd0, 16'd1),
               p16(16'h5640, 16'hD640, 16'h6801, 16'hE800, 16'h0000, 16'h0000, 16'h0000, 16'h3C00),
               "R7 i16->f16 mixed");

    // R8: hold while idle
    @(negedge clk);
    valid_i = 1'b0;
    op_i    = 2'd2;
    vec_i   = {VEC_W{1'b1}};
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(valid_o === 1'b0, "R8 valid_o low when idle", {{(VEC_W-1){1'b0}}, valid_o}, '0);
      chk(vec_o === p16(16'h5640, 16'hD640, 16'h6801, 16'hE800, 16'h0000, 16'h0000, 16'h0000, 16'h3C00),
          "R8 vec_o holds", vec_o,
          p16(16'h5640, 16'hD640, 16'h6801, 16'hE800, 16'h0000, 16'h0000, 16'h0000, 16'h3C00));
    end
    chk(exp_q.size() == 0, "R8 all results delivered", VEC_W'(exp_q.size()), '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule